// File: doc/BRIEF.md
# Keyed Clock and Power Controller

This block holds the two control registers of a small clock unit: a clock register that picks the clock source and the timer's slow-clock source, and a power register that holds the CPU clock divider, a fast-interrupt flag and a power-down request. Software cannot change either register with a single bus write. Each register needs a three-step sequence on the register bus. First a preamble key is written, then the data, then a postamble key. Each register has its own pair of keys and its own sequence tracker, so a stray write cannot change the clock tree.

From the reference clock, the block makes `cpu_en`, a one-cycle enable pulse that repeats every 2^n reference cycles. When the fast-interrupt flag is set and an interrupt is being serviced, the divider is bypassed and `cpu_en` is high every cycle. A power-down request stops `cpu_en` and raises `pwr_down`. Only reset or the `wake` input ends this state. The real oscillators, the PLL and the glitch-free clock muxing are not modelled. The source select is only an output code.

Each key tracker is a three-state machine:

- States: `SEQ_IDLE`, `SEQ_ARMED`, `SEQ_LOADED`.
- Arm: `SEQ_IDLE` goes to `SEQ_ARMED` on a correct preamble.
- Capture: `SEQ_ARMED` goes to `SEQ_LOADED` on a data write.
- Abort: `SEQ_ARMED` or `SEQ_LOADED` goes to `SEQ_IDLE` on any other write to its group.
- Commit: `SEQ_LOADED` goes to `SEQ_IDLE` on a correct postamble. This also updates the register.

The power machine has two states and two transitions:

- States: `PWR_RUN`, `PWR_SLEEP`.
- Sleep: `PWR_RUN` goes to `PWR_SLEEP` when a commit sets the power-down bit.
- Wake: `PWR_SLEEP` goes to `PWR_RUN` when `wake` is high.

Top module: `clkpwr_keyctl`

## Requirements
- R1: After reset, `clk_mode`=0, `slow_clk_int`=0, `div_sel`=0, `fast_irq_en`=0 and `pwr_down`=0, and `cpu_en` is high in every cycle.
- R2: Three writes update the clock register:
  - 0xAA to address 0x0, then the data to address 0x1, then 0x55 to address 0x2.
  - Data bits [1:0] go to `clk_mode`: 0 internal oscillator, 1 PLL with 32 kHz crystal, 2 external input A, 3 external input B.
  - Data bit 2 goes to `slow_clk_int`.
  - The new value is visible in the cycle after the edge that samples the postamble.
- R3: Neither register changes before its postamble key has been accepted. A preamble plus data alone leaves the old value in place.
- R4: A preamble write with the wrong key value does not start a sequence. A following data write and postamble then change nothing.
- R5: Any write to one of a register's three addresses that is not the expected next step returns its tracker to idle, and the register keeps its value. This covers:
  - a wrong postamble value;
  - a postamble with no data before it;
  - a repeated preamble while the postamble is awaited.

  Writes to other addresses and idle cycles do not disturb a sequence in progress.
- R6: Three writes update the power register:
  - 0x01 to address 0x8, then the data to address 0x9, then 0xF4 to address 0xA.
  - Data bits [2:0] go to `div_sel`, bit 3 is the power-down request and bit 4 goes to `fast_irq_en`.
  - The two trackers are independent, so their sequences may be interleaved on the bus.
- R7: With `div_sel`=n and no bypass or power-down, `cpu_en` is high for one cycle out of every 2^n cycles (n=0..7).
- R8: A new `div_sel` takes effect at the next `cpu_en` pulse. The period already running finishes at its old length, and no shortened period occurs.
- R9: While `fast_irq_en`=1 and `irq_active`=1, `cpu_en` is high in every cycle, starting in the cycle `irq_active` rises. With `fast_irq_en`=0, `irq_active` has no effect. After the bypass ends, `cpu_en` pulses in the first cycle and a full new period follows.
- R10: A power-register commit with bit 3 set raises `pwr_down` one cycle after the register fields update. While `pwr_down` is high, `cpu_en` stays low, even with fast interrupt and `irq_active` both set.
- R11: A `wake` pulse during power-down clears `pwr_down` at the edge that samples it. `cpu_en` is high in that first cycle, and the period restarts from there. A `wake` pulse while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register bus write strobe |
| wr_addr | input | 4 | Register bus write address |
| wr_data | input | 8 | Register bus write data |
| irq_active | input | 1 | High while an interrupt is being serviced |
| wake | input | 1 | Leaves power-down |
| clk_mode | output | 2 | Selected clock source code |
| slow_clk_int | output | 1 | 1: internal 32 kHz clock for the timer, 0: external crystal |
| div_sel | output | 3 | CPU divider exponent n (ratio 2^n) |
| fast_irq_en | output | 1 | Fast-interrupt flag |
| pwr_down | output | 1 | High while in power-down |
| cpu_en | output | 1 | Divided CPU clock enable |

## Verification
Register outputs change on the edge that samples a correct postamble and are due at the next sample. `pwr_down` follows one edge later, and leaves power-down on the very edge that samples `wake`. `cpu_en` responds to `irq_active` within the same cycle. Otherwise it follows a counter that reloads only on a pulse.

Inputs change on falling edges, and every output is read 2 ns after a rising edge. The driver queues the expected register snapshot after each bus task returns, and the monitor compares it at the next sample. The monitor also checks `cpu_en` against a cycle-by-cycle period model built from the previously observed port values.

// File: rtl/ckp_pkg.sv
package ckp_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;

    // Register bus map: one group of three addresses per guarded register
    localparam logic [ADDR_W-1:0] CLK_KEY1_ADDR = 4'h0;
    localparam logic [ADDR_W-1:0] CLK_CTRL_ADDR = 4'h1;
    localparam logic [ADDR_W-1:0] CLK_KEY2_ADDR = 4'h2;
    localparam logic [ADDR_W-1:0] PWR_KEY1_ADDR = 4'h8;
    localparam logic [ADDR_W-1:0] PWR_CTRL_ADDR = 4'h9;
    localparam logic [ADDR_W-1:0] PWR_KEY2_ADDR = 4'hA;

    localparam logic [DATA_W-1:0] CLK_KEY1_VAL = 8'hAA;
    localparam logic [DATA_W-1:0] CLK_KEY2_VAL = 8'h55;
    localparam logic [DATA_W-1:0] PWR_KEY1_VAL = 8'h01;
    localparam logic [DATA_W-1:0] PWR_KEY2_VAL = 8'hF4;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ARMED  = 2'd1,
        SEQ_LOADED = 2'd2
    } seq_state_t;

    typedef enum logic {
        PWR_RUN   = 1'b0,
        PWR_SLEEP = 1'b1
    } pwr_state_t;

    // bit 2 slow clock select, bits 1:0 source code
    typedef struct packed {
        logic       slow_int;
        logic [1:0] mode;
    } clk_reg_t;

    // bit 4 fast interrupt, bit 3 power-down request, bits 2:0 divider
    typedef struct packed {
        logic             fint;
        logic             pd;
        logic [SEL_W-1:0] div;
    } pwr_reg_t;

    localparam int CLK_REG_W = $bits(clk_reg_t);
    localparam int PWR_REG_W = $bits(pwr_reg_t);

endpackage

// File: rtl/ckp_key_seq.sv
module ckp_key_seq
    import ckp_pkg::*;
#(
    parameter int                AW        = 4,
    parameter int                DW        = 8,
    parameter int                RW        = 3,
    parameter logic [AW-1:0]     KEY1_ADDR = '0,
    parameter logic [AW-1:0]     CTRL_ADDR = 1,
    parameter logic [AW-1:0]     KEY2_ADDR = 2,
    parameter logic [DW-1:0]     KEY1_VAL  = 8'hAA,
    parameter logic [DW-1:0]     KEY2_VAL  = 8'h55,
    parameter logic [RW-1:0]     RST_VAL   = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [RW-1:0] value_o,
    output logic          commit_o
);

    seq_state_t    state_q, state_d;
    logic [RW-1:0] pend_q;
    logic [RW-1:0] value_q;
    logic          commit_q;

    logic hit_k1, hit_ctrl, hit_k2, hit_any;
    logic key1_ok, key2_ok;
    logic capture, commit;

    always_comb begin
        hit_k1   = wr_en && (wr_addr == KEY1_ADDR);
        hit_ctrl = wr_en && (wr_addr == CTRL_ADDR);
        hit_k2   = wr_en && (wr_addr == KEY2_ADDR);
        hit_any  = hit_k1 || hit_ctrl || hit_k2;
        key1_ok  = hit_k1 && (wr_data == KEY1_VAL);
        key2_ok  = hit_k2 && (wr_data == KEY2_VAL);
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (key1_ok) state_d = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (hit_ctrl)     state_d = SEQ_LOADED;
                else if (hit_any) state_d = SEQ_IDLE;
            end
            SEQ_LOADED: begin
                if (hit_any) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Outputs of the sequence: capture and commit strobes
    always_comb begin
        capture = (state_q == SEQ_ARMED)  && hit_ctrl;
        commit  = (state_q == SEQ_LOADED) && key2_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= RST_VAL;
            value_q  <= RST_VAL;
            commit_q <= 1'b0;
        end else begin
            if (capture) pend_q  <= wr_data[RW-1:0];
            if (commit)  value_q <= pend_q;
            commit_q <= commit;
        end
    end

    assign value_o  = value_q;
    assign commit_o = commit_q;

    // R3: the held value moves only right after an accepted postamble
    assert_hold_until_postamble_R3: assert property (@(posedge clk) disable iff (rst)
        (value_q != $past(value_q)) |-> $past(state_q == SEQ_LOADED && key2_ok));

    // R5: any unexpected write to the group drops the tracker back to idle
    assert_abort_to_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q != SEQ_IDLE && hit_any && !(state_q == SEQ_ARMED && hit_ctrl))
        |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/ckp_clk_div.sv
module ckp_clk_div #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             bypass,
    input  logic             halt,
    output logic             tick
);

    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    // 2^sel - 1 as a mask of sel ones
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            reload[i] = (i < int'(sel));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (halt || bypass) begin
            cnt_q <= '0;
        end else if (cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = !halt && (bypass || (cnt_q == '0));

    // Period checker: spacing between two plain pulses matches the ratio
    // latched at the first of them
    logic             armed_q;
    logic [CNT_W-1:0] gap_q;
    logic [SEL_W-1:0] psel_q;
    logic [CNT_W-1:0] exp_gap;

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            exp_gap[i] = (i < int'(psel_q));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            gap_q   <= '0;
            psel_q  <= '0;
        end else if (halt || bypass) begin
            armed_q <= 1'b0;
        end else if (cnt_q == '0) begin
            armed_q <= 1'b1;
            gap_q   <= '0;
            psel_q  <= sel;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R8: a period is never cut short by a divider change
    assert_period_R8: assert property (@(posedge clk) disable iff (rst)
        (!halt && !bypass && cnt_q == '0 && armed_q) |-> (gap_q == exp_gap));

endmodule

// File: rtl/ckp_pwr_fsm.sv
module ckp_pwr_fsm
    import ckp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic pd_req,
    input  logic wake,
    output logic sleep
);

    pwr_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PWR_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: wake wins over a same-cycle sleep request
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN: begin
                if (commit && pd_req && !wake) state_d = PWR_SLEEP;
            end
            PWR_SLEEP: begin
                if (wake) state_d = PWR_RUN;
            end
            default: state_d = PWR_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        sleep = (state_q == PWR_SLEEP);
    end

    assert_wake_exits_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == PWR_SLEEP && wake) |=> (state_q == PWR_RUN));

    assert_wake_keeps_run_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == PWR_RUN && wake) |=> (state_q == PWR_RUN));

endmodule

// File: rtl/clkpwr_keyctl.sv
module clkpwr_keyctl
    import ckp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_active,
    input  logic              wake,
    output logic [1:0]        clk_mode,
    output logic              slow_clk_int,
    output logic [SEL_W-1:0]  div_sel,
    output logic              fast_irq_en,
    output logic              pwr_down,
    output logic              cpu_en
);

    clk_reg_t clk_q;
    pwr_reg_t pwr_q;
    logic     clk_commit;
    logic     pwr_commit;
    logic     sleep;
    logic     bypass;

    ckp_key_seq #(
        .AW        (ADDR_W),
        .DW        (DATA_W),
        .RW        (CLK_REG_W),
        .KEY1_ADDR (CLK_KEY1_ADDR),
        .CTRL_ADDR (CLK_CTRL_ADDR),
        .KEY2_ADDR (CLK_KEY2_ADDR),
        .KEY1_VAL  (CLK_KEY1_VAL),
        .KEY2_VAL  (CLK_KEY2_VAL),
        .RST_VAL   ('0)
    ) u_clk_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .value_o  (clk_q),
        .commit_o (clk_commit)
    );

    ckp_key_seq #(
        .AW        (ADDR_W),
        .DW        (DATA_W),
        .RW        (PWR_REG_W),
        .KEY1_ADDR (PWR_KEY1_ADDR),
        .CTRL_ADDR (PWR_CTRL_ADDR),
        .KEY2_ADDR (PWR_KEY2_ADDR),
        .KEY1_VAL  (PWR_KEY1_VAL),
        .KEY2_VAL  (PWR_KEY2_VAL),
        .RST_VAL   ('0)
    ) u_pwr_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .value_o  (pwr_q),
        .commit_o (pwr_commit)
    );

    ckp_pwr_fsm u_pwr_fsm (
        .clk    (clk),
        .rst    (rst),
        .commit (pwr_commit),
        .pd_req (pwr_q.pd),
        .wake   (wake),
        .sleep  (sleep)
    );

    assign bypass = pwr_q.fint && irq_active;

    ckp_clk_div #(
        .SEL_W (SEL_W)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .sel    (pwr_q.div),
        .bypass (bypass),
        .halt   (sleep),
        .tick   (cpu_en)
    );

    assign clk_mode     = clk_q.mode;
    assign slow_clk_int = clk_q.slow_int;
    assign div_sel      = pwr_q.div;
    assign fast_irq_en  = pwr_q.fint;
    assign pwr_down     = sleep;

    // R2: a clock commit is always preceded by a correct postamble write
    assert_clk_commit_key_R2: assert property (@(posedge clk) disable iff (rst)
        clk_commit |-> $past(wr_en && wr_addr == CLK_KEY2_ADDR && wr_data == CLK_KEY2_VAL));

    // R6: same for the power register
    assert_pwr_commit_key_R6: assert property (@(posedge clk) disable iff (rst)
        pwr_commit |-> $past(wr_en && wr_addr == PWR_KEY2_ADDR && wr_data == PWR_KEY2_VAL));

    // R9: interrupt service with fast mode runs at full rate
    assert_bypass_full_rate_R9: assert property (@(posedge clk) disable iff (rst)
        (fast_irq_en && irq_active && !pwr_down) |-> cpu_en);

    // R10: no enable pulse while powered down
    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> !cpu_en);

endmodule

// File: tb/test_clkpwr_keyctl.sv
module test_clkpwr_keyctl;
    import ckp_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq_active = 1'b0;
    logic       wake = 1'b0;
    logic [1:0] clk_mode;
    logic       slow_clk_int;
    logic [2:0] div_sel;
    logic       fast_irq_en;
    logic       pwr_down;
    logic       cpu_en;

    always #4 clk = ~clk;   // 125 MHz

    clkpwr_keyctl i_clkpwr_keyctl (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .irq_active   (irq_active),
        .wake         (wake),
        .clk_mode     (clk_mode),
        .slow_clk_int (slow_clk_int),
        .div_sel      (div_sel),
        .fast_irq_en  (fast_irq_en),
        .pwr_down     (pwr_down),
        .cpu_en       (cpu_en)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    typedef struct {
        string      req;
        logic [1:0] mode;
        logic       slow;
        logic [2:0] div;
        logic       fint;
        logic       pd;
    } exp_t;

    exp_t sb_q[$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: cycle model of cpu_en plus scoreboard of register snapshots
    int         m_cnt = 0;
    logic       p_pd = 1'b0;
    logic       p_fint = 1'b0;
    logic [2:0] p_div = '0;

    always begin
        @(posedge clk);
        #2;
        if (rst) begin
            m_cnt  = 0;
            p_pd   = 1'b0;
            p_fint = 1'b0;
            p_div  = '0;
        end else begin
            logic exp_en;
            if (p_pd || (p_fint && irq_active)) m_cnt = 0;
            else if (m_cnt == 0)                m_cnt = (1 << p_div) - 1;
            else                                m_cnt = m_cnt - 1;
            exp_en = !pwr_down && ((fast_irq_en && irq_active) || (m_cnt == 0));
            chk(cur_req, "cpu_en", int'(cpu_en), int'(exp_en));
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.req, "clk_mode",     int'(clk_mode),     int'(e.mode));
                chk(e.req, "slow_clk_int", int'(slow_clk_int), int'(e.slow));
                chk(e.req, "div_sel",      int'(div_sel),      int'(e.div));
                chk(e.req, "fast_irq_en",  int'(fast_irq_en),  int'(e.fint));
                chk(e.req, "pwr_down",     int'(pwr_down),     int'(e.pd));
            end
            p_pd   = pwr_down;
            p_fint = fast_irq_en;
            p_div  = div_sel;
        end
    end

    task automatic push_exp(input string req, input logic [1:0] mode, input logic slow,
                            input logic [2:0] div, input logic fint, input logic pd);
        exp_t e;
        e.req = req; e.mode = mode; e.slow = slow; e.div = div; e.fint = fint; e.pd = pd;
        sb_q.push_back(e);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic clk_seq(input logic [7:0] k1, input logic [7:0] d, input logic [7:0] k2);
        bus_wr(CLK_KEY1_ADDR, k1);
        bus_wr(CLK_CTRL_ADDR, d);
        bus_wr(CLK_KEY2_ADDR, k2);
    endtask

    task automatic pwr_seq(input logic [7:0] k1, input logic [7:0] d, input logic [7:0] k2);
        bus_wr(PWR_KEY1_ADDR, k1);
        bus_wr(PWR_CTRL_ADDR, d);
        bus_wr(PWR_KEY2_ADDR, k2);
    endtask

    task automatic wake_pulse();
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset values, full-rate enable
        cur_req = "R1";
        push_exp("R1", 2'd0, 1'b0, 3'd0, 1'b0, 1'b0);
        repeat (6) @(negedge clk);

        // R2: full clock sequence, mode 2 with internal slow clock
        cur_req = "R2";
        clk_seq(8'hAA, 8'h06, 8'h55);
        push_exp("R2", 2'd2, 1'b1, 3'd0, 1'b0, 1'b0);

        // R3: nothing lands before the postamble
        cur_req = "R3";
        bus_wr(CLK_KEY1_ADDR, 8'hAA);
        bus_wr(CLK_CTRL_ADDR, 8'h01);
        push_exp("R3", 2'd2, 1'b1, 3'd0, 1'b0, 1'b0);
        bus_wr(CLK_KEY2_ADDR, 8'h55);
        push_exp("R3", 2'd1, 1'b0, 3'd0, 1'b0, 1'b0);

        // R4: wrong preamble value
        cur_req = "R4";
        clk_seq(8'hAB, 8'h03, 8'h55);
        push_exp("R4", 2'd1, 1'b0, 3'd0, 1'b0, 1'b0);

        // R5: aborts and harmless foreign writes
        cur_req = "R5";
        clk_seq(8'hAA, 8'h03, 8'h56);
        push_exp("R5", 2'd1, 1'b0, 3'd0, 1'b0, 1'b0);
        bus_wr(CLK_KEY1_ADDR, 8'hAA);
        bus_wr(CLK_KEY2_ADDR, 8'h55);
        push_exp("R5", 2'd1, 1'b0, 3'd0, 1'b0, 1'b0);
        bus_wr(CLK_KEY1_ADDR, 8'hAA);
        bus_wr(CLK_CTRL_ADDR, 8'h03);
        bus_wr(CLK_KEY1_ADDR, 8'hAA);
        bus_wr(CLK_KEY2_ADDR, 8'h55);
        push_exp("R5", 2'd1, 1'b0, 3'd0, 1'b0, 1'b0);
        bus_wr(CLK_KEY1_ADDR, 8'hAA);
        bus_wr(4'h5, 8'h00);
        bus_wr(CLK_CTRL_ADDR, 8'h03);
        bus_wr(4'h7, 8'hFF);
        repeat (3) @(negedge clk);
        bus_wr(CLK_KEY2_ADDR, 8'h55);
        push_exp("R5", 2'd3, 1'b0, 3'd0, 1'b0, 1'b0);

        // R6: interleaved sequences, then a bad power postamble
        cur_req = "R6";
        bus_wr(CLK_KEY1_ADDR, 8'hAA);
        bus_wr(PWR_KEY1_ADDR, 8'h01);
        bus_wr(CLK_CTRL_ADDR, 8'h01);
        bus_wr(PWR_CTRL_ADDR, 8'h02);
        bus_wr(CLK_KEY2_ADDR, 8'h55);
        bus_wr(PWR_KEY2_ADDR, 8'hF4);
        push_exp("R6", 2'd1, 1'b0, 3'd2, 1'b0, 1'b0);
        pwr_seq(8'h01, 8'h03, 8'h55);
        push_exp("R6", 2'd1, 1'b0, 3'd2, 1'b0, 1'b0);

        // R7: divided enable at several ratios
        cur_req = "R7";
        repeat (24) @(negedge clk);
        pwr_seq(8'h01, 8'h00, 8'hF4);
        push_exp("R7", 2'd1, 1'b0, 3'd0, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        pwr_seq(8'h01, 8'h07, 8'hF4);
        push_exp("R7", 2'd1, 1'b0, 3'd7, 1'b0, 1'b0);
        repeat (300) @(negedge clk);

        // R8: change inside a long period, then inside a short one
        cur_req = "R8";
        repeat (40) @(negedge clk);
        pwr_seq(8'h01, 8'h01, 8'hF4);
        push_exp("R8", 2'd1, 1'b0, 3'd1, 1'b0, 1'b0);
        repeat (140) @(negedge clk);
        pwr_seq(8'h01, 8'h03, 8'hF4);
        push_exp("R8", 2'd1, 1'b0, 3'd3, 1'b0, 1'b0);
        repeat (30) @(negedge clk);

        // R9: fast interrupt bypass on and off
        cur_req = "R9";
        pwr_seq(8'h01, 8'h13, 8'hF4);
        push_exp("R9", 2'd1, 1'b0, 3'd3, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        irq_active = 1'b1;
        repeat (12) @(negedge clk);
        irq_active = 1'b0;
        repeat (20) @(negedge clk);
        pwr_seq(8'h01, 8'h03, 8'hF4);
        push_exp("R9", 2'd1, 1'b0, 3'd3, 1'b0, 1'b0);
        irq_active = 1'b1;
        repeat (20) @(negedge clk);
        irq_active = 1'b0;
        repeat (5) @(negedge clk);

        // R10: power-down holds enable low, even with bypass requested
        cur_req = "R10";
        pwr_seq(8'h01, 8'h1B, 8'hF4);
        push_exp("R10", 2'd1, 1'b0, 3'd3, 1'b1, 1'b1);
        irq_active = 1'b1;
        repeat (30) @(negedge clk);
        irq_active = 1'b0;
        repeat (5) @(negedge clk);

        // R11: wake leaves power-down; a second wake while running does nothing
        cur_req = "R11";
        wake_pulse();
        push_exp("R11", 2'd1, 1'b0, 3'd3, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        wake_pulse();
        push_exp("R11", 2'd1, 1'b0, 3'd3, 1'b1, 1'b0);
        repeat (20) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL %s watchdog: actual hung expected finished", cur_req);
            summary();
            $finish;
        end
    end

endmodule